// File: doc/BRIEF.md
# Serial Even-Parity Inserter

This block sits on a one-bit serial path and turns a stream of data bits into a stream of framed messages. Each bit arrives with a valid strobe. Every group of three data bits is followed by one generated check bit. The check bit is chosen so that the four bits of the frame hold an even number of ones. The output is a serial bit with its own valid flag, plus a marker that is high only for the generated bit. Each data bit appears on the output in the same cycle it arrives.

The generated bit takes one valid input beat. The input bit offered in that beat is discarded. An upstream source therefore leaves a gap in its data for every fourth accepted beat. The message length is a parameter with a default of 3. A second parameter chooses between a binary and a one-hot slot counter.

Top module: `serial_parity_inserter`

## Requirements
- R1: After a synchronous active-high reset, the frame position is the first data slot and the accumulated parity is 0. The first valid beat after reset is therefore a data beat.
- R2: In a data slot with `in_valid`=1, `out_valid`=1, `par_slot`=0 and `out_bit` equals `in_bit`, all in the same cycle.
- R3: Once MSG_BITS (default 3) valid data beats have been taken since reset or since the last check beat, the next valid beat is a check beat. In a check beat `par_slot`=1 and `out_valid`=1. No other beat has `par_slot`=1.
- R4: In a check beat, `out_bit` is the XOR of the data bits of the current message. The data bits plus the check bit therefore carry an even count of ones.
- R5: The `in_bit` value offered during a check beat is ignored. It has no effect on `out_bit` in that beat or on any later beat.
- R6: After a check beat, a new message starts with parity 0 at the first data slot.
- R7: With `in_valid`=0, `out_valid`=0, `par_slot`=0 and `out_bit`=0. The frame position and the parity are held, and the message continues when beats resume.
- R8: A reset in the middle of a frame drops the partial message. The next valid beat is the first data slot of a new message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat strobe |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output beat strobe |
| out_bit | output | 1 | Serial output bit (data or check bit) |
| par_slot | output | 1 | High while the output beat is the generated check bit |

## Verification
The assertions run on every cycle and check the following:
- data pass-through;
- the quiet outputs when the strobe is low;
- that a check beat comes only after exactly MSG_BITS data beats;
- that the check bit matches an independently tracked parity;
- that the parity clears after each check beat;
- the legal states of the counter.

Some behaviours only the bench scenarios can show:
- that an ignored check-beat input leaves later frames unchanged;
- that strobe gaps in the middle of a message are bridged correctly;
- that a reset in the middle of a frame drops the partial message.

The bench shows these by comparing whole output streams against a behavioural model.

// File: rtl/par_ins_pkg.sv
package par_ins_pkg;

   typedef enum logic [1:0] {
      BEAT_IDLE   = 2'd0,
      BEAT_DATA   = 2'd1,
      BEAT_CHECK  = 2'd2
   } beat_kind_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pi_slot_counter.sv
module pi_slot_counter #(
   parameter int unsigned MSG_BITS   = 3,
   parameter bit          ONE_HOT    = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic last
);
   localparam int unsigned SLOTS = MSG_BITS + 1;
   localparam int unsigned CW    = par_ins_pkg::cnt_width(SLOTS);

   initial begin
      assert (MSG_BITS >= 1) else $fatal(1, "MSG_BITS must be at least 1");
   end

   generate
      if (ONE_HOT) begin : g_onehot
         logic [SLOTS-1:0] hot_q;

         always_ff @(posedge clk) begin
            if (rst)      hot_q <= {{(SLOTS-1){1'b0}}, 1'b1};
            else if (adv) hot_q <= {hot_q[SLOTS-2:0], hot_q[SLOTS-1]};
         end

         assign last = hot_q[SLOTS-1];

         // R1
         slot_reset_chk: assert property (@(posedge clk) rst |=> hot_q[0]);
         // R3
         slot_legal_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(hot_q) == 1);
      end else begin : g_binary
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)           cnt_q <= '0;
            else if (adv) begin
               if (last)       cnt_q <= '0;
               else            cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last = (cnt_q == CW'(MSG_BITS));

         // R1
         slot_reset_chk: assert property (@(posedge clk) rst |=> (cnt_q == '0));
         // R3
         slot_legal_chk: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= CW'(MSG_BITS));
      end
   endgenerate

endmodule

// File: rtl/pi_parity_acc.sv
module pi_parity_acc (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic last,
   input  logic din,
   output logic par
);
   logic par_q;

   always_ff @(posedge clk) begin
      if (rst)                par_q <= 1'b0;
      else if (adv && last)   par_q <= 1'b0;
      else if (adv)           par_q <= par_q ^ din;
   end

   assign par = par_q;

   // R6
   par_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && last) |=> !par_q);
   // R7
   par_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(par_q));

endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_bit,
   input  logic last,
   input  logic par,
   output logic out_valid,
   output logic out_bit,
   output logic par_slot
);
   import par_ins_pkg::*;

   beat_kind_t kind;

   always_comb begin
      if (!in_valid)  kind = BEAT_IDLE;
      else if (last)  kind = BEAT_CHECK;
      else            kind = BEAT_DATA;
   end

   always_comb begin
      out_valid = 1'b0;
      out_bit   = 1'b0;
      par_slot  = 1'b0;
      unique case (kind)
         BEAT_DATA: begin
            out_valid = 1'b1;
            out_bit   = in_bit;
         end
         BEAT_CHECK: begin
            out_valid = 1'b1;
            out_bit   = par;
            par_slot  = 1'b1;
         end
         default: ;
      endcase
   end

   // R2
   data_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !par_slot) |-> (out_bit == in_bit));
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> (!out_valid && !par_slot && !out_bit));

endmodule

// File: rtl/serial_parity_inserter.sv
module serial_parity_inserter #(
   parameter int unsigned MSG_BITS = 3,
   parameter bit          ONE_HOT  = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit,
   output logic par_slot
);
   localparam int unsigned CW = par_ins_pkg::cnt_width(MSG_BITS + 1);

   logic last;
   logic par;

   pi_slot_counter #(.MSG_BITS(MSG_BITS), .ONE_HOT(ONE_HOT)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .adv  (in_valid),
      .last (last)
   );

   pi_parity_acc u_par (
      .clk  (clk),
      .rst  (rst),
      .adv  (in_valid),
      .last (last),
      .din  (in_bit),
      .par  (par)
   );

   pi_out_stage u_out (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .last      (last),
      .par       (par),
      .out_valid (out_valid),
      .out_bit   (out_bit),
      .par_slot  (par_slot)
   );

   // Independent tracking of the output stream, used only by the checks
   logic [CW-1:0] seen_data_q;
   logic          seen_par_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_data_q <= '0;
         seen_par_q  <= 1'b0;
      end else if (out_valid && par_slot) begin
         seen_data_q <= '0;
         seen_par_q  <= 1'b0;
      end else if (out_valid) begin
         seen_data_q <= seen_data_q + 1'b1;
         seen_par_q  <= seen_par_q ^ out_bit;
      end
   end

   // R3
   check_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      par_slot |-> (seen_data_q == CW'(MSG_BITS)));
   // R3
   check_due_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && seen_data_q == CW'(MSG_BITS)) |-> par_slot);
   // R4
   even_parity_chk: assert property (@(posedge clk) disable iff (rst)
      par_slot |-> (out_bit == seen_par_q));

endmodule

// File: tb/serial_parity_inserter_test.sv
`timescale 1ns/1ps
module serial_parity_inserter_test;
   localparam int MSG = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic out_valid, out_bit, par_slot;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   int ref_cnt = 0;
   int ref_par = 0;
   bit last_out;

   always #2.5 clk = ~clk;

   serial_parity_inserter #(.MSG_BITS(MSG)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
      .out_valid(out_valid), .out_bit(out_bit), .par_slot(par_slot)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      ref_cnt = 0; ref_par = 0;
   endtask

   // one cycle: drive, compare before the edge, advance the model
   task automatic beat(input bit v, input bit b);
      bit e_valid, e_bit, e_slot;
      @(negedge clk);
      in_valid = v; in_bit = b;
      #1;
      e_valid = v;
      e_slot  = v && (ref_cnt == MSG);
      e_bit   = !v ? 1'b0 : (e_slot ? ref_par[0] : b);
      check(out_valid == e_valid, v ? "R2" : "R7", out_valid, e_valid);
      check(par_slot == e_slot, v ? "R3" : "R7", par_slot, e_slot);
      check(out_bit == e_bit, !v ? "R7" : (e_slot ? "R4" : "R2"), out_bit, e_bit);
      last_out = out_bit;
      if (v) begin
         if (ref_cnt == MSG) begin ref_cnt = 0; ref_par = 0; end
         else begin ref_cnt++; ref_par ^= int'(b); end
      end
   endtask

   initial begin
      bit p_a, p_b;
      do_reset();
      // R1: reset state, outputs quiet, then first beat is data
      #1;
      check(out_valid == 1'b0 && par_slot == 1'b0, "R1", out_valid, 0);
      beat(1'b1, 1'b1);
      check(par_slot == 1'b0, "R1", par_slot, 0);

      // R4: every data pattern, check-beat input alternating
      do_reset();
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < MSG; i++) beat(1'b1, p[i]);
         beat(1'b1, p[0]);
         check(last_out == ^p[2:0], "R4", last_out, ^p[2:0]);
      end

      // R5: check-beat input ignored
      beat(1'b1, 1'b1); beat(1'b1, 1'b0); beat(1'b1, 1'b0);
      beat(1'b1, 1'b0); p_a = last_out;
      beat(1'b1, 1'b1); beat(1'b1, 1'b0); beat(1'b1, 1'b0);
      beat(1'b1, 1'b1); p_b = last_out;
      check(p_a == p_b, "R5", p_b, p_a);
      beat(1'b1, 1'b0); beat(1'b1, 1'b0); beat(1'b1, 1'b0);
      beat(1'b1, 1'b1);
      check(last_out == 1'b0, "R5", last_out, 0);

      // R6: 111 then 000 gives 1 then fresh 0
      for (int i = 0; i < MSG; i++) beat(1'b1, 1'b1);
      beat(1'b1, 1'b0);
      check(last_out == 1'b1, "R6", last_out, 1);
      for (int i = 0; i < MSG; i++) beat(1'b1, 1'b0);
      beat(1'b1, 1'b0);
      check(last_out == 1'b0, "R6", last_out, 0);

      // R7: gaps inside a message
      beat(1'b1, 1'b1); beat(1'b0, 1'b1); beat(1'b0, 1'b0);
      beat(1'b1, 1'b1); beat(1'b0, 1'b1); beat(1'b1, 1'b1);
      beat(1'b0, 1'b1); beat(1'b1, 1'b0);
      check(last_out == 1'b1, "R7", last_out, 1);

      // R8: reset mid-frame
      beat(1'b1, 1'b1); beat(1'b1, 1'b0);
      do_reset();
      for (int i = 0; i < MSG; i++) beat(1'b1, 1'b0);
      check(par_slot == 1'b0, "R8", par_slot, 0);
      beat(1'b1, 1'b1);
      check(last_out == 1'b0, "R8", last_out, 0);

      // mixed random stream
      for (int n = 0; n < 400; n++) beat(($urandom % 4) != 0, $urandom % 2);

      @(negedge clk);
      in_valid = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule